// File: doc/BRIEF.md
# PS/2 Device-Side Frame Transmitter

This block is the sending half of a PS/2 peripheral. It accepts one byte at a time over a valid/ready handshake and keeps it in a one-entry buffer. When the two open-drain bus lines have both stayed high for a full bit time, it produces the serial clock itself and shifts out an 11-bit frame. The frame is a low start bit, the byte least significant bit first, an odd parity bit and a high stop bit.

The block never drives a line high. For each line it has a pull-low enable, and it reads the resolved line back through a two-flop synchronizer. While a frame is in progress it watches the released clock. If the host holds the clock low before the tenth rising edge, the block drops the frame, frees both lines and keeps the byte for another attempt from the start bit. Once the tenth rising edge has passed, the byte counts as delivered and the buffer is free to take the next one. If the host holds the clock high and pulls the data line low while the block is waiting, no frame starts and a flag tells the receive path that the host wants to talk.

Top module: `ps2_dev_tx`

## Requirements
- R1: An uninterrupted frame has exactly 11 clock pulses, all generated by the block. Each low phase lasts HALF_TICKS system cycles and each high phase lasts HALF_TICKS system cycles.
- R2: At the falling edges of the clock the data line carries these values in order:
  - 0
  - byte bits 0 to 7
  - the odd parity bit, which is 1 when the byte has an even number of ones
  - 1
- R3: A frame starts only after both lines have been seen high for 2*HALF_TICKS consecutive cycles. While the host holds the clock low, no clock pulse is produced.
- R4: While the block is waiting and sees the clock high and the data low, `host_req_o` is 1. During that time no frame starts and both pull-low outputs stay 0.
- R5: The data line changes only while the clock is high, HALF_TICKS/2 cycles after the rising edge. It holds the same value from before each falling edge until after the next rising edge.
- R6: If the host holds the clock low before the tenth rising edge, the block releases both lines and keeps `in_ready` at 0. The same byte is then resent as a complete frame after the bus has been idle for a bit time.
- R7: At the tenth rising edge `in_ready` returns to 1, even if the host pulls the clock low afterwards. A frame inhibited after that edge is not sent again.
- R8: `in_ready` is 1 only when the buffer is empty, and a byte is taken when `in_valid` and `in_ready` are both 1. While `in_ready` is 0, `in_valid` has no effect.
- R9: After reset `in_ready` is 1, both pull-low outputs are 0 and `host_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Byte to send |
| in_ready | output | 1 | Buffer empty, byte can be taken |
| ps2_clk_i | input | 1 | Resolved bus clock line, read back |
| ps2_data_i | input | 1 | Resolved bus data line, read back |
| ps2_clk_low_o | output | 1 | 1 pulls the bus clock low, 0 releases it |
| ps2_data_low_o | output | 1 | 1 pulls the bus data low, 0 releases it |
| host_req_o | output | 1 | Host request to send seen while waiting |

## Verification
A wrong phase counter or a wrong edge counter shows up on the bus within one bit time. The symptoms are a low phase of the wrong width, a twelfth pulse, or a data change that lands inside a low phase. A bad frame shift register shows at the very first falling edge of the next frame, as a wrong start bit or a misplaced byte bit. A buffer that is freed too early or too late shows at `in_ready`, either during an abort or in the cycle of the tenth rising edge. The host-side model inhibits the bus at chosen edges so that these windows are observed directly.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;

    localparam int FRAME_BITS   = 11;
    localparam int DELIVER_EDGE = 10;

    typedef logic [FRAME_BITS-1:0] frame_t;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_SETUP,
        ST_LOW,
        ST_HIGH
    } tx_state_e;

    typedef struct packed {
        logic clk_low;
        logic data_low;
    } line_drive_t;

    function automatic logic odd_parity(input logic [7:0] b);
        return ~(^b);
    endfunction

    // Bit 0 leaves first: start, byte LSB first, parity, stop.
    function automatic frame_t build_frame(input logic [7:0] b);
        frame_t f;
        f[0]   = 1'b0;
        f[8:1] = b;
        f[9]   = odd_parity(b);
        f[10]  = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], async_i[i]};
        end
        assign sync_o[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/ps2_tick_counter.sv
module ps2_tick_counter #(
    parameter int WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    output logic [WIDTH-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clear)     count <= '0;
        else if (count != '1) count <= count + 1'b1;
    end
endmodule

// File: rtl/ps2_tx_buffer.sv
module ps2_tx_buffer (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       release_i,
    output logic       full_o,
    output logic [7:0] byte_o
);
    logic       full_q;
    logic [7:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            byte_q <= '0;
        end else if (release_i) begin
            full_q <= 1'b0;
        end else if (in_valid && !full_q) begin
            full_q <= 1'b1;
            byte_q <= in_byte;
        end
    end

    assign full_o = full_q;
    assign byte_o = byte_q;

    AST_KEEP_UNTIL_DELIVERED: assert property (@(posedge clk) disable iff (rst)
        (full_q && !release_i) |=> (full_q && $stable(byte_q))); // R6
    AST_TAKE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !full_q && !release_i) |=> full_q); // R8
endmodule

// File: rtl/ps2_tx_engine.sv
module ps2_tx_engine
    import ps2_tx_pkg::*;
#(
    parameter int HALF_TICKS  = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clk_s,
    input  logic        data_s,
    input  logic        buf_full,
    input  logic [7:0]  buf_byte,
    output logic        deliver_o,
    output logic        host_req_o,
    output line_drive_t drive_o
);
    localparam int IDLE_TICKS = 2 * HALF_TICKS;
    localparam int MID_TICKS  = HALF_TICKS / 2;
    localparam int GUARD      = SYNC_STAGES + 1;
    localparam int CW         = $clog2(IDLE_TICKS + 1);
    localparam int EW         = $clog2(FRAME_BITS + 1);

    localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_TICKS - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF_TICKS - 1);
    localparam logic [CW-1:0] MID_LAST  = CW'(MID_TICKS - 1);
    localparam logic [CW-1:0] GUARD_C   = CW'(GUARD);
    localparam logic [EW-1:0] LAST_EDGE = EW'(FRAME_BITS);
    localparam logic [EW-1:0] DLV_EDGE  = EW'(DELIVER_EDGE);

    tx_state_e       state_q, state_d;
    frame_t          shreg_q, shreg_d;
    logic [EW-1:0]   edges_q, edges_d;
    logic [CW-1:0]   cnt;
    logic            cnt_clr;
    logic            host_holds;

    ps2_tick_counter #(.WIDTH(CW)) u_phase_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clr),
        .count (cnt)
    );

    // Released clock seen low once the readback has had time to settle.
    assign host_holds = !clk_s && (cnt >= GUARD_C);

    always_comb begin
        state_d   = state_q;
        shreg_d   = shreg_q;
        edges_d   = edges_q;
        cnt_clr   = 1'b0;
        deliver_o = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (!buf_full || !clk_s || !data_s) begin
                    cnt_clr = 1'b1;
                end else if (cnt == IDLE_LAST) begin
                    state_d = ST_SETUP;
                    cnt_clr = 1'b1;
                    shreg_d = build_frame(buf_byte);
                    edges_d = '0;
                end
            end
            ST_SETUP: begin
                if (host_holds) begin
                    state_d = ST_WAIT;
                    cnt_clr = 1'b1;
                    shreg_d = '1;
                end else if (cnt == HALF_LAST) begin
                    state_d = ST_LOW;
                    cnt_clr = 1'b1;
                end
            end
            ST_LOW: begin
                if (cnt == HALF_LAST) begin
                    state_d = ST_HIGH;
                    cnt_clr = 1'b1;
                    edges_d = edges_q + 1'b1;
                    if (edges_q == DLV_EDGE - 1'b1) deliver_o = 1'b1;
                end
            end
            ST_HIGH: begin
                if (host_holds && (edges_q < DLV_EDGE)) begin
                    state_d = ST_WAIT;
                    cnt_clr = 1'b1;
                    shreg_d = '1;
                end else begin
                    if (cnt == MID_LAST) shreg_d = {1'b1, shreg_q[FRAME_BITS-1:1]};
                    if (cnt == HALF_LAST) begin
                        cnt_clr = 1'b1;
                        state_d = (edges_q == LAST_EDGE) ? ST_WAIT : ST_LOW;
                    end
                end
            end
            default: state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
            shreg_q <= '1;
            edges_q <= '0;
        end else begin
            state_q <= state_d;
            shreg_q <= shreg_d;
            edges_q <= edges_d;
        end
    end

    assign drive_o.clk_low  = (state_q == ST_LOW);
    assign drive_o.data_low = (state_q != ST_WAIT) && !shreg_q[0];
    assign host_req_o       = (state_q == ST_WAIT) && clk_s && !data_s;

    AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        edges_q <= LAST_EDGE); // R1
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETUP) |-> drive_o.data_low); // R2
    AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETUP && $past(state_q) == ST_WAIT) |-> ($past(clk_s) && $past(data_s))); // R3
    AST_RTS_LINES_FREE: assert property (@(posedge clk) disable iff (rst)
        host_req_o |-> (!drive_o.clk_low && !drive_o.data_low)); // R4
    AST_DATA_STEADY_LOW: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOW || $past(state_q) == ST_LOW) |-> $stable(drive_o.data_low)); // R5
    AST_DELIVER_AT_TENTH: assert property (@(posedge clk) disable iff (rst)
        deliver_o |=> (state_q == ST_HIGH && edges_q == DLV_EDGE)); // R7
endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx
    import ps2_tx_pkg::*;
#(
    parameter int HALF_TICKS  = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    input  logic       ps2_clk_i,
    input  logic       ps2_data_i,
    output logic       ps2_clk_low_o,
    output logic       ps2_data_low_o,
    output logic       host_req_o
);
    logic [1:0]  lines_s;
    logic        buf_full;
    logic [7:0]  buf_byte;
    logic        deliver;
    line_drive_t drive;

    ps2_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ps2_clk_i, ps2_data_i}),
        .sync_o  (lines_s)
    );

    ps2_tx_buffer u_buf (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .release_i (deliver),
        .full_o    (buf_full),
        .byte_o    (buf_byte)
    );

    ps2_tx_engine #(.HALF_TICKS(HALF_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .clk_s      (lines_s[1]),
        .data_s     (lines_s[0]),
        .buf_full   (buf_full),
        .buf_byte   (buf_byte),
        .deliver_o  (deliver),
        .host_req_o (host_req_o),
        .drive_o    (drive)
    );

    assign in_ready       = !buf_full;
    assign ps2_clk_low_o  = drive.clk_low;
    assign ps2_data_low_o = drive.data_low;
endmodule

// File: tb/ps2_dev_tx_bench.sv
`timescale 1ns/1ps
module ps2_dev_tx_bench;
    localparam int HALF = 8;
    localparam real LOW_NS = HALF * 4.0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_ready;
    logic       dut_clk_low, dut_data_low, host_req;
    logic       host_clk_low = 1'b0;
    logic       host_data_low = 1'b0;
    wire        line_clk  = ~(dut_clk_low | host_clk_low);
    wire        line_data = ~(dut_data_low | host_data_low);

    int errs = 0;
    int checks = 0;

    always #2 clk = ~clk;

    ps2_dev_tx #(.HALF_TICKS(HALF), .SYNC_STAGES(2)) u_ps2_dev_tx (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_byte        (in_byte),
        .in_ready       (in_ready),
        .ps2_clk_i      (line_clk),
        .ps2_data_i     (line_data),
        .ps2_clk_low_o  (dut_clk_low),
        .ps2_data_low_o (dut_data_low),
        .host_req_o     (host_req)
    );

    // Bus monitor (host side)
    logic        mon_on = 1'b0;
    int          falls = 0;
    int          rises = 0;
    int          width_bad = 0;
    int          stable_bad = 0;
    logic [31:0] cap;
    logic        data_at_fall;
    realtime     t_fall;

    always @(negedge line_clk) if (mon_on) begin
        if (falls < 32) cap[falls] = line_data;
        data_at_fall = line_data;
        t_fall = $realtime;
        falls++;
    end

    always @(posedge line_clk) if (mon_on) begin
        rises++;
        if (line_data !== data_at_fall) stable_bad++;
        if (($realtime - t_fall) < LOW_NS - 0.5 || ($realtime - t_fall) > LOW_NS + 0.5) width_bad++;
    end

    function automatic logic [10:0] exp_frame(input logic [7:0] b);
        return {1'b1, ~(^b), b, 1'b0};
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic mon_reset();
        falls = 0; rises = 0; width_bad = 0; stable_bad = 0; cap = '0;
        mon_on = 1'b1;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_falls(input int n);
        for (int i = 0; i < 3000 && falls < n; i++) @(negedge clk);
    endtask

    task automatic wait_rises(input int n);
        for (int i = 0; i < 3000 && rises < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(in_ready === 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);
        check(dut_clk_low === 1'b0 && dut_data_low === 1'b0, "R9", "lines released after reset",
              int'({dut_clk_low, dut_data_low}), 0);
        check(host_req === 1'b0, "R9", "host_req after reset", int'(host_req), 0);
    endtask

    task automatic t_send(input logic [7:0] b);
        mon_reset();
        push(b);
        wait_falls(11);
        repeat (3 * HALF) @(negedge clk);
        check(falls == 11, "R1", "clock pulses per frame", falls, 11);
        check(width_bad == 0, "R1", "low phase width errors", width_bad, 0);
        check(cap[10:0] == exp_frame(b), "R2", "frame bits", int'(cap[10:0]), int'(exp_frame(b)));
        check(stable_bad == 0, "R5", "data changed in low phase", stable_bad, 0);
        check(in_ready === 1'b1, "R7", "buffer free after frame", int'(in_ready), 1);
    endtask

    task automatic t_inhibit();
        int waited;
        mon_on = 1'b0;
        @(negedge clk);
        host_clk_low = 1'b1;
        @(negedge clk);
        mon_reset();
        push(8'h5A);
        repeat (100) @(negedge clk);
        check(falls == 0, "R3", "pulses while inhibited", falls, 0);
        mon_on = 1'b0;
        host_clk_low = 1'b0;
        @(negedge clk);
        mon_reset();
        waited = 1;
        while (falls == 0 && waited < 500) begin
            @(negedge clk);
            waited++;
        end
        check(waited >= 3 * HALF && waited <= 3 * HALF + 6, "R3", "cycles from release to first pulse",
              waited, 3 * HALF + 2);
        wait_falls(11);
        repeat (3 * HALF) @(negedge clk);
        check(cap[10:0] == exp_frame(8'h5A), "R3", "frame after inhibit", int'(cap[10:0]),
              int'(exp_frame(8'h5A)));
    endtask

    task automatic t_rts();
        @(negedge clk);
        host_data_low = 1'b1;
        mon_reset();
        push(8'h81);
        repeat (60) @(negedge clk);
        check(host_req === 1'b1, "R4", "host_req during request", int'(host_req), 1);
        check(falls == 0, "R4", "pulses during host request", falls, 0);
        check(dut_data_low === 1'b0 && dut_clk_low === 1'b0, "R4", "lines released during request",
              int'({dut_clk_low, dut_data_low}), 0);
        host_data_low = 1'b0;
        wait_falls(11);
        repeat (3 * HALF) @(negedge clk);
        check(host_req === 1'b0, "R4", "host_req after request", int'(host_req), 0);
        check(cap[10:0] == exp_frame(8'h81), "R4", "frame after request", int'(cap[10:0]),
              int'(exp_frame(8'h81)));
    endtask

    task automatic t_abort();
        mon_reset();
        push(8'h96);
        wait_falls(4);
        mon_on = 1'b0;
        repeat (2) @(negedge clk);
        host_clk_low = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        check(dut_clk_low === 1'b0 && dut_data_low === 1'b0, "R6", "lines released on abort",
              int'({dut_clk_low, dut_data_low}), 0);
        check(in_ready === 1'b0, "R6", "byte kept on abort", int'(in_ready), 0);
        repeat (20) @(negedge clk);
        host_clk_low = 1'b0;
        @(negedge clk);
        mon_reset();
        wait_falls(11);
        repeat (3 * HALF) @(negedge clk);
        check(falls == 11, "R6", "retry pulse count", falls, 11);
        check(cap[10:0] == exp_frame(8'h96), "R6", "retried frame", int'(cap[10:0]),
              int'(exp_frame(8'h96)));
        check(in_ready === 1'b1, "R6", "buffer free after retry", int'(in_ready), 1);
    endtask

    task automatic t_late_inhibit();
        mon_reset();
        push(8'h4E);
        wait_rises(10);
        mon_on = 1'b0;
        host_clk_low = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1, "R7", "buffer freed at tenth edge", int'(in_ready), 1);
        repeat (40) @(negedge clk);
        host_clk_low = 1'b0;
        @(negedge clk);
        mon_reset();
        repeat (150) @(negedge clk);
        check(falls == 0, "R7", "no resend after tenth edge", falls, 0);
    endtask

    task automatic t_back_to_back();
        mon_reset();
        push(8'hE7);
        wait_rises(10);
        @(negedge clk);
        check(in_ready === 1'b1, "R7", "ready during frame tail", int'(in_ready), 1);
        push(8'h18);
        wait_falls(22);
        repeat (3 * HALF) @(negedge clk);
        check(cap[10:0] == exp_frame(8'hE7), "R7", "first of two frames", int'(cap[10:0]),
              int'(exp_frame(8'hE7)));
        check(cap[21:11] == exp_frame(8'h18), "R7", "second of two frames", int'(cap[21:11]),
              int'(exp_frame(8'h18)));
    endtask

    task automatic t_ignore_valid();
        mon_reset();
        push(8'h3C);
        @(negedge clk);
        check(in_ready === 1'b0, "R8", "ready low with full buffer", int'(in_ready), 0);
        in_valid = 1'b1;
        in_byte  = 8'hC3;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        wait_falls(11);
        repeat (100) @(negedge clk);
        check(cap[10:0] == exp_frame(8'h3C), "R8", "offered byte ignored", int'(cap[10:0]),
              int'(exp_frame(8'h3C)));
        check(falls == 11, "R8", "no extra frame", falls, 11);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_send(8'h00);
        t_send(8'hFF);
        t_send(8'hA5);
        t_send(8'h01);
        t_inhibit();
        t_rts();
        t_abort();
        t_late_inhibit();
        t_back_to_back();
        t_ignore_valid();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule